// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a single-port static RAM whose every command is captured on the rising clock edge. The memory word is split into byte lanes of nine bits each, so the default build holds 18-bit words and a four-lane build holds 36-bit words. A command can give a fresh address on every cycle. It can also open a four-beat burst, in which a 2-bit counter inside the block supplies the following addresses each time the advance input is high.

Three static strap inputs set the timing. The first picks linear or interleaved burst order. The second picks whether read data bypasses the output register (flow-through) or passes through it (pipelined). The third picks whether the output bus stays driven for one extra slot after a deselect. Writes can go to selected byte lanes, or to the whole word at once. The output enable gates the read bus and its valid flag without waiting for a clock.

Top module: `sync_burst_sram`

## Requirements
- R1: With `ord_linear_i`=1 the burst beat i (i=0..3) goes to address {upper bits of start, (start[1:0]+i) mod 4}. The upper address bits never change inside a burst.
- R2: With `ord_linear_i`=0 the burst beat i goes to address {upper bits of start, start[1:0] XOR i}.
- R3: A cycle with either `strb_host_i` or `strb_ctl_i` high and `ce_i`=1 starts an access at `addr_i` and clears the burst count. Back-to-back strobe cycles each access their own address, with no idle cycle between them.
- R4: In a cycle with no strobe inside an open burst, `adv_i`=0 accesses the same address again and `adv_i`=1 moves to the next beat.
- R5: A strobe cycle with `ce_i`=0 deselects the block and writes nothing. Later cycles with no strobe also write nothing and read nothing, until the next strobe with `ce_i`=1.
- R6: A cycle is a byte write when `bwe_i`=1 and at least one bit of `bsel_i` is set. Bit n of `bsel_i` writes lane n, which is `wdata_i[9n+8:9n]`. The other lanes keep their contents. With `bwe_i`=0, or with no bits set in `bsel_i`, the access is a read.
- R7: `gwe_i`=1 writes all lanes whatever the values of `bwe_i` and `bsel_i`.
- R8: With `rd_pipe_i`=0, a read captured at edge k is valid on `rdata_o` in the cycle right after edge k.
- R9: With `rd_pipe_i`=1, a read captured at edge k is valid only after edge k+1.
- R10: With `desel_dual_i`=0, the output slot of any command that is not a read is undriven. With `desel_dual_i`=1, a non-access cycle that directly follows a read keeps the bus driven with the same data for one more slot.
- R11: `rvalid_o` is the internal drive flag ANDed with `oe_i`. `rdata_o` is all zeros whenever `rvalid_o` is 0. Both follow `oe_i` with no clock edge.
- R12: A read of an address written in the cycle before returns the new data, in both read modes.
- R13: After reset no burst is open and `rvalid_o`=0 with `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ord_linear_i | input | 1 | Burst order strap: 1 linear, 0 interleaved |
| rd_pipe_i | input | 1 | Read strap: 1 pipelined, 0 flow-through |
| desel_dual_i | input | 1 | Deselect strap: 1 dual-cycle, 0 single-cycle |
| ce_i | input | 1 | Chip enable, sampled on strobe cycles |
| strb_host_i | input | 1 | Address strobe, first source |
| strb_ctl_i | input | 1 | Address strobe, second source |
| adv_i | input | 1 | Burst advance |
| addr_i | input | ADDR_W | Word address |
| gwe_i | input | 1 | Global write, all lanes |
| bwe_i | input | 1 | Byte write enable |
| bsel_i | input | LANES | Per-lane write selects |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | LANES*LANE_W | Read data, zero when undriven |
| rvalid_o | output | 1 | Read bus driven |

## Verification
The bench builds the block with four lanes (36-bit words) and a 6-bit address. This makes four byte-lane selects available, so non-adjacent lane patterns can be tested, and it keeps the array small enough to fill completely. Burst tests start at an address whose low bits are 01, where linear and interleaved orders give different sequences, and the wrap inside the four-word group can be seen. Every combination of read mode and deselect mode is run through a reset, so the extra driven slot and the added cycle of latency are each measured against the other mode.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a burst beat: sum (linear) or XOR (interleaved).
  function automatic beat_t beat_ofs(input beat_t lo, input beat_t cnt, input logic linear);
    beat_ofs = linear ? beat_t'(lo + cnt) : (lo ^ cnt);
  endfunction
endpackage

// File: rtl/sbs_burst_addr.sv
`timescale 1ns/1ps
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              linear_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            active_q, active_d;
  logic [HI_W-1:0] hi_q, hi_d;
  beat_t           lo_q, lo_d;
  beat_t           cnt_q, cnt_d;
  beat_t           cnt_nx;
  logic            cont;

  always_comb begin
    cont       = active_q & ~start_i & ~stop_i;
    cnt_nx     = adv_i ? beat_t'(cnt_q + beat_t'(1)) : cnt_q;
    acc_o      = start_i | cont;
    acc_addr_o = start_i ? addr_i : {hi_q, beat_ofs(lo_q, cnt_nx, linear_i)};
  end

  always_comb begin
    active_d = active_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    cnt_d    = cnt_q;
    if (start_i) begin
      active_d = 1'b1;
      hi_d     = addr_i[ADDR_W-1:BEAT_W];
      lo_d     = addr_i[BEAT_W-1:0];
      cnt_d    = '0;
    end else if (stop_i) begin
      active_d = 1'b0;
    end else if (cont) begin
      cnt_d = cnt_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  p_load_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && cnt_q == '0));
  p_cnt_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start_i && !stop_i && adv_i) |=> cnt_q == beat_t'($past(cnt_q) + beat_t'(1)));
  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !adv_i) |=> $stable(cnt_q));
  p_stop_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !active_q);
endmodule

// File: rtl/sbs_write_ctl.sv
`timescale 1ns/1ps
module sbs_write_ctl #(
  parameter int LANES = 2
) (
  input  logic             acc_i,
  input  logic             gwe_i,
  input  logic             bwe_i,
  input  logic [LANES-1:0] bsel_i,
  output logic             wr_o,
  output logic [LANES-1:0] lane_we_o
);
  logic [LANES-1:0] mask;

  always_comb begin
    if (gwe_i)      mask = '1;
    else if (bwe_i) mask = bsel_i;
    else            mask = '0;
    wr_o      = acc_i & (|mask);
    lane_we_o = wr_o ? mask : '0;
  end
endmodule

// File: rtl/sbs_lane_array.sv
`timescale 1ns/1ps
module sbs_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sbs_read_path.sv
`timescale 1ns/1ps
module sbs_read_path #(
  parameter int ADDR_W = 10,
  parameter int DW     = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              dual_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DW-1:0]     mem_q_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              drv_o,
  output logic [DW-1:0]     data_o
);
  logic              rd_now;
  logic              s1_rd_q, s1_rd_d;
  logic              s1_hold_q, s1_hold_d;
  logic [ADDR_W-1:0] s1_addr_q;
  logic              p_drv_q, p_drv_d;
  logic [DW-1:0]     p_dat_q;

  always_comb begin
    rd_now    = acc_i & ~wr_i;
    s1_rd_d   = rd_now;
    s1_hold_d = dual_i & ~acc_i & s1_rd_q;
    p_drv_d   = s1_rd_q | s1_hold_q;
    raddr_o   = s1_addr_q;
    drv_o     = pipe_i ? p_drv_q : (s1_rd_q | s1_hold_q);
    data_o    = pipe_i ? p_dat_q : mem_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_rd_q   <= 1'b0;
      s1_hold_q <= 1'b0;
      p_drv_q   <= 1'b0;
    end else begin
      s1_rd_q   <= s1_rd_d;
      s1_hold_q <= s1_hold_d;
      p_drv_q   <= p_drv_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_now)  s1_addr_q <= acc_addr_i;
    if (s1_rd_q) p_dat_q   <= mem_q_i;
  end

  p_scd_off_flow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && !dual_i && !rd_now) |=> !drv_o);
  p_flow_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_i && rd_now) |=> drv_o);
  p_pipe_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && rd_now) |=> ##1 drv_o);
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ord_linear_i,
  input  logic                    rd_pipe_i,
  input  logic                    desel_dual_i,
  input  logic                    ce_i,
  input  logic                    strb_host_i,
  input  logic                    strb_ctl_i,
  input  logic                    adv_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    gwe_i,
  input  logic                    bwe_i,
  input  logic [LANES-1:0]        bsel_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  localparam int DW = LANES * LANE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              strobe, start, stop;
  logic              acc, wr;
  logic [ADDR_W-1:0] acc_addr, raddr;
  logic [LANES-1:0]  lane_we;
  logic [DW-1:0]     mem_q, out_dat;
  logic              drv;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    strobe = strb_host_i | strb_ctl_i;
    start  = strobe & ce_i;
    stop   = strobe & ~ce_i;
  end

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .linear_i  (ord_linear_i),
    .start_i   (start),
    .stop_i    (stop),
    .adv_i     (adv_i),
    .addr_i    (addr_i),
    .acc_o     (acc),
    .acc_addr_o(acc_addr)
  );

  sbs_write_ctl #(.LANES(LANES)) u_wctl (
    .acc_i    (acc),
    .gwe_i    (gwe_i),
    .bwe_i    (bwe_i),
    .bsel_i   (bsel_i),
    .wr_o     (wr),
    .lane_we_o(lane_we)
  );

  sbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (lane_we),
    .waddr_i(acc_addr),
    .wdata_i(wdata_i),
    .raddr_i(raddr),
    .rdata_o(mem_q)
  );

  sbs_read_path #(.ADDR_W(ADDR_W), .DW(DW)) u_rpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pipe_i    (rd_pipe_i),
    .dual_i    (desel_dual_i),
    .acc_i     (acc),
    .wr_i      (wr),
    .acc_addr_i(acc_addr),
    .mem_q_i   (mem_q),
    .raddr_o   (raddr),
    .drv_o     (drv),
    .data_o    (out_dat)
  );

  always_comb begin
    rvalid_o = drv & oe_i;
    rdata_o  = rvalid_o ? out_dat : '0;
  end

  p_desel_nowrite_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (strobe && !ce_i) |-> lane_we == '0);
  p_gwe_all_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start && gwe_i) |-> &lane_we);
endmodule

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/1ps
module sync_burst_sram_tb;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk, rst_n, lin, pipe, dual, ce, sh, sc, adv, gwe, bwe, oe;
  logic [AW-1:0] addr;
  logic [LN-1:0] bsel;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  logic [DW-1:0] model [64];
  int n_cmp = 0;
  int n_bad = 0;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ord_linear_i(lin), .rd_pipe_i(pipe),
    .desel_dual_i(dual), .ce_i(ce), .strb_host_i(sh), .strb_ctl_i(sc),
    .adv_i(adv), .addr_i(addr), .gwe_i(gwe), .bwe_i(bwe), .bsel_i(bsel),
    .wdata_i(wdata), .oe_i(oe), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    pat = {3'b101, a, 3'b010, a, 3'b110, a, 3'b001, a};
  endfunction

  task automatic chk(input string tag, input logic v_exp, input logic [DW-1:0] d_exp);
    n_cmp++;
    if (rvalid !== v_exp || rdata !== d_exp) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               tag, rvalid, rdata, v_exp, d_exp);
    end
  endtask

  task automatic cyc(input logic h, input logic c, input logic e, input logic a_v,
                     input logic [AW-1:0] a, input logic g, input logic b,
                     input logic [LN-1:0] s, input logic [DW-1:0] d);
    sh = h; sc = c; ce = e; adv = a_v; addr = a; gwe = g; bwe = b; bsel = s; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic des();  cyc(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0); endtask
  task automatic rd(input logic [AW-1:0] a); cyc(1'b0, 1'b1, 1'b1, 1'b0, a, 1'b0, 1'b0, '0, '0); endtask
  task automatic cont(input logic a_v); cyc(1'b0, 1'b0, 1'b1, a_v, '0, 1'b0, 1'b0, '0, '0); endtask

  task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, a, 1'b1, 1'b0, '0, d);
    model[a] = d;
  endtask

  task automatic do_reset(input logic l, input logic p, input logic d2);
    rst_n = 1'b0;
    lin = l; pipe = p; dual = d2; oe = 1'b1;
    sh = 0; sc = 0; ce = 0; adv = 0; addr = '0; gwe = 0; bwe = 0; bsel = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R13 reset idle", 1'b0, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 64; a++) begin
      if (a[0]) cyc(1'b1, 1'b0, 1'b1, 1'b0, AW'(a), 1'b1, 1'b0, '0, pat(AW'(a)));
      else      cyc(1'b0, 1'b1, 1'b1, 1'b0, AW'(a), 1'b1, 1'b0, '0, pat(AW'(a)));
      model[a] = pat(AW'(a));
    end
    des();
    chk("R5 deselected after fill", 1'b0, '0);
  endtask

  task automatic t_flow_reads();
    do_reset(1'b0, 1'b0, 1'b0);
    rd(6'd3);  chk("R8 flow read 3", 1'b1, model[3]);
    rd(6'd17); chk("R3 back-to-back read 17", 1'b1, model[17]);
    rd(6'd40); chk("R3 back-to-back read 40", 1'b1, model[40]);
    des();     chk("R10 scd flow off", 1'b0, '0);
  endtask

  task automatic t_pipe_reads();
    do_reset(1'b0, 1'b1, 1'b0);
    rd(6'd10); chk("R9 pipe not yet valid", 1'b0, '0);
    rd(6'd11); chk("R9 pipe read 10", 1'b1, model[10]);
    des();     chk("R9 pipe read 11", 1'b1, model[11]);
    des();     chk("R10 scd pipe off", 1'b0, '0);
  endtask

  task automatic t_burst(input logic l);
    logic [AW-1:0] st;
    logic [1:0]    lo;
    st = 6'd21;
    do_reset(l, 1'b1, 1'b0);
    rd(st);
    for (int i = 1; i < 4; i++) begin
      cont(1'b1);
      lo = l ? 2'(st[1:0] + 2'(i - 1)) : (st[1:0] ^ 2'(i - 1));
      chk(l ? "R1 linear beat" : "R2 interleaved beat", 1'b1, model[{st[AW-1:2], lo}]);
    end
    des();
    lo = l ? 2'(st[1:0] + 2'd3) : (st[1:0] ^ 2'd3);
    chk(l ? "R1 linear last beat" : "R2 interleaved last beat", 1'b1, model[{st[AW-1:2], lo}]);
  endtask

  task automatic t_hold();
    do_reset(1'b0, 1'b0, 1'b0);
    rd(6'd30);   chk("R4 start 30", 1'b1, model[30]);
    cont(1'b0);  chk("R4 hold 30", 1'b1, model[30]);
    cont(1'b1);  chk("R4 advance to 31", 1'b1, model[31]);
    cont(1'b0);  chk("R4 hold 31", 1'b1, model[31]);
    des();
  endtask

  task automatic t_desel();
    do_reset(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 6'd5, 1'b1, 1'b0, '0, ~pat(6'd5));
    chk("R5 deselect strobe not driven", 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 6'd6, 1'b1, 1'b0, '0, ~pat(6'd6));
    chk("R5 no-strobe while idle not driven", 1'b0, '0);
    rd(6'd5); chk("R5 addr 5 unchanged", 1'b1, model[5]);
    rd(6'd6); chk("R5 addr 6 unchanged", 1'b1, model[6]);
    des();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] nd;
    do_reset(1'b0, 1'b0, 1'b0);
    nd = {DW{1'b1}};
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 6'd40, 1'b0, 1'b1, 4'b0101, nd);
    for (int l = 0; l < LN; l++)
      if (l == 0 || l == 2) model[40][l*LW +: LW] = nd[l*LW +: LW];
    rd(6'd40); chk("R6 lanes 0 and 2 only", 1'b1, model[40]);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 6'd40, 1'b0, 1'b0, 4'b1111, '0);
    chk("R6 selects without enable read", 1'b1, model[40]);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 6'd40, 1'b0, 1'b1, 4'b0000, '0);
    chk("R6 enable without selects read", 1'b1, model[40]);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 6'd41, 1'b1, 1'b1, 4'b0001, '0);
    model[41] = '0;
    rd(6'd41); chk("R7 global overrides byte selects", 1'b1, model[41]);
    des();
  endtask

  task automatic t_raw();
    do_reset(1'b0, 1'b0, 1'b0);
    wr_all(6'd50, 36'h123456789);
    rd(6'd50); chk("R12 flow read after write", 1'b1, model[50]);
    des();
    do_reset(1'b0, 1'b1, 1'b0);
    wr_all(6'd51, 36'h9abcdef01);
    rd(6'd51);
    des(); chk("R12 pipe read after write", 1'b1, model[51]);
    des();
  endtask

  task automatic t_dual();
    do_reset(1'b0, 1'b0, 1'b1);
    rd(6'd12); chk("R10 dcd flow read", 1'b1, model[12]);
    des();     chk("R10 dcd flow extra slot", 1'b1, model[12]);
    des();     chk("R10 dcd flow off", 1'b0, '0);
    do_reset(1'b0, 1'b1, 1'b1);
    rd(6'd13);
    des();     chk("R10 dcd pipe read", 1'b1, model[13]);
    des();     chk("R10 dcd pipe extra slot", 1'b1, model[13]);
    des();     chk("R10 dcd pipe off", 1'b0, '0);
  endtask

  task automatic t_oe();
    do_reset(1'b0, 1'b0, 1'b0);
    rd(6'd7); chk("R11 oe high valid", 1'b1, model[7]);
    oe = 1'b0; #1;
    chk("R11 oe low gates bus", 1'b0, '0);
    oe = 1'b1; #1;
    chk("R11 oe restored", 1'b1, model[7]);
    des();
  endtask

  initial begin : main
    t_reset();
    t_fill();
    t_flow_reads();
    t_pipe_reads();
    t_burst(1'b1);
    t_burst(1'b0);
    t_hold();
    t_desel();
    t_bytes();
    t_raw();
    t_dual();
    t_oe();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got running, expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule